// File: doc/BRIEF.md
# Paired-Register Doubleword Load/Store Sequencer

This block carries out 64-bit loads and stores on a 32-bit core whose registers come in even/odd pairs. The pipeline hands it one decoded operation: direction, base register value and index, a signed 12-bit displacement and the index of the data pair. The block forms the effective address and checks the operand. It then issues two 32-bit word transactions on a valid/ready memory port that allows one transaction in flight. Load data returns to the register file through a single write port. Store data is read through a single read port.

The even register of a pair always holds bits 31:0 and the odd register holds bits 63:32. When a load's data pair overlaps its own base register, the word bound for the base is fetched and written last. A fault on the other word then leaves the base intact, so the operation can be restarted. Register 0 as a load destination discards both words, and as a store source it supplies 64 zero bits without a register read. The pipeline sees `busy` for the whole operation and a one-cycle `done` that carries any trap.

Top module: `lsp_pair_unit`

## Requirements
- R1: The effective address is the base value plus the sign-extended 12-bit displacement. The word for bits 31:0 goes to that address and the word for bits 63:32 to that address plus 4.
- R2: An odd data index raises trap cause 1 (illegal). No memory transaction and no register write take place. This check takes priority over the alignment check.
- R3: An effective address with bits 1:0 not zero raises trap cause 2 (misaligned) with `trap_addr` equal to the effective address. No memory transaction takes place. Every transaction address has bits 1:0 equal to zero.
- R4: Addresses that are a multiple of 8, and addresses that are a multiple of 4 but not of 8, both complete as two word transactions with no trap.
- R5: A load writes the word read from the effective address to the even register and the word from the address plus 4 to the odd register.
- R6: When a load's data index equals its base index, the upper word is fetched and written first. In every other case the lower word goes first. A register write never targets the base register before the other write of the same operation.
- R7: An error response on the first transaction raises trap cause 3 (access) with `trap_addr` equal to that transaction's address. No register is written and no second transaction is issued.
- R8: An error response on the second transaction raises trap cause 3 with that transaction's address. The first word's register has already been written, and the base register keeps its value.
- R9: A load to pair 0 performs both reads and writes no register. No write ever targets register 0 or 1.
- R10: A store from pair 0 writes zero in both transactions, and `rf_re` stays low.
- R11: A store reads the even register for the lower transaction and the odd register for the upper one, in lower-then-upper order, with `mem_req_we` high.
- R12: `busy` is high from the cycle after acceptance until the cycle after `done`. `done` lasts exactly one cycle per operation. `op_valid` is ignored while `busy` is high. A request held without `mem_req_ready` keeps its address.
- R13: During and after reset, `busy`, `done`, `mem_req_valid` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered (taken when not busy) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_base | input | 32 | Base register value |
| op_base_idx | input | 5 | Base register index |
| op_offset | input | 12 | Signed displacement |
| op_data_idx | input | 5 | Data pair index (must be even) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap_valid | output | 1 | Trap with this completion |
| trap_cause | output | 2 | 0 none, 1 illegal, 2 misaligned, 3 access |
| trap_addr | output | 32 | Address that caused the trap |
| mem_req_valid | output | 1 | Word transaction request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write |
| mem_req_addr | output | 32 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_err | input | 1 | Response is an access error |
| mem_rsp_rdata | input | 32 | Read data |
| rf_re | output | 1 | Register read strobe |
| rf_raddr | output | 5 | Register read index |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |

## Verification
The operation patterns are chosen to separate the address and ordering rules. One pattern uses a positive displacement and another a negative one, which exposes a zero-extended offset. A 4-aligned address that is not 8-aligned shows that no extra trap is raised. Loads whose base coincides with the even or the odd register of the pair distinguish the reversed write order from the normal one. Error responses on the first and on the second word, for both orders and for stores, show which register writes survive a fault. Pair 0 as destination and as source, odd indices with and without a misaligned address, request stalls and `op_valid` held while busy cover the operand rules, the trap priority and the handshake.

// File: rtl/lsp_pkg.sv
// Shared types for the paired-register load/store sequencer.
// Assumes: a 2-bit trap cause field decoded by the pipeline.
package lsp_pkg;
    typedef enum logic [1:0] {
        TRAP_NONE     = 2'd0,
        TRAP_ILLEGAL  = 2'd1,
        TRAP_MISALIGN = 2'd2,
        TRAP_ACCESS   = 2'd3
    } trap_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_FIN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/lsp_addr_gen.sv
// Effective address and operand check.
// Computes base + sign-extended displacement and decides the up-front trap:
// odd data index -> illegal (first priority), address not word aligned ->
// misaligned. Purely combinational; assumes inputs are stable while offered.
module lsp_addr_gen
    import lsp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 12,
    parameter int IDX_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IDX_W-1:0]  data_idx,
    output logic [ADDR_W-1:0] ea,
    output trap_e             cause
);
    localparam int LOW_BITS = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] off_ext;
    logic              odd_idx;
    logic              mis;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        ea      = base + off_ext;
    end

    // Trap decision with illegal-operand priority over alignment.
    always_comb begin
        odd_idx = data_idx[0];
        mis     = (ea[LOW_BITS-1:0] != '0);
        if (odd_idx)
            cause = TRAP_ILLEGAL;
        else if (mis)
            cause = TRAP_MISALIGN;
        else
            cause = TRAP_NONE;
    end
endmodule

// File: rtl/lsp_seq_ctrl.sv
// Word sequencer for one paired operation.
// Latches an accepted operation, picks which word goes first (upper word
// first when a load's pair overlaps its base at the even register), issues
// the two word transactions one at a time and ends with a one-cycle done
// carrying the trap outcome. Assumes at most one response per request.
module lsp_seq_ctrl
    import lsp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [IDX_W-1:0]  op_base_idx,
    input  logic [IDX_W-1:0]  op_data_idx,
    input  logic [ADDR_W-1:0] ea_in,
    input  trap_e             chk_cause,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              busy,
    output logic              done,
    output logic              trap_valid,
    output trap_e             trap_cause,
    output logic [ADDR_W-1:0] trap_addr,
    output logic              issue,
    output logic              rsp_ok,
    output logic              word_hi,
    output logic              cur_store,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [ADDR_W-1:0] word_addr
);
    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(WORD_BYTES);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] ea_q;
    logic              store_q;
    logic [IDX_W-1:0]  idx_q;
    logic              first_hi_q;
    logic              pos_q;
    trap_e             cause_q;
    logic [ADDR_W-1:0] taddr_q;
    logic              first_hi_d;

    // Upper word first only for a load whose even register is the base.
    always_comb begin
        first_hi_d = !op_store && (op_data_idx != '0) && (op_base_idx == op_data_idx);
    end

    // Current word selection and its address.
    always_comb begin
        word_hi   = first_hi_q ^ pos_q;
        word_addr = ea_q + (word_hi ? HI_STEP : '0);
    end

    // Operation state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ea_q       <= '0;
            store_q    <= 1'b0;
            idx_q      <= '0;
            first_hi_q <= 1'b0;
            pos_q      <= 1'b0;
            cause_q    <= TRAP_NONE;
            taddr_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (op_valid) begin
                        ea_q       <= ea_in;
                        store_q    <= op_store;
                        idx_q      <= op_data_idx;
                        first_hi_q <= first_hi_d;
                        pos_q      <= 1'b0;
                        if (chk_cause != TRAP_NONE) begin
                            cause_q <= chk_cause;
                            taddr_q <= ea_in;
                            state_q <= S_FIN;
                        end else begin
                            cause_q <= TRAP_NONE;
                            taddr_q <= '0;
                            state_q <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (mem_req_ready)
                        state_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            cause_q <= TRAP_ACCESS;
                            taddr_q <= word_addr;
                            state_q <= S_FIN;
                        end else if (pos_q) begin
                            state_q <= S_FIN;
                        end else begin
                            pos_q   <= 1'b1;
                            state_q <= S_ISSUE;
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Status and handshake outputs decoded from state.
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_FIN);
        issue      = (state_q == S_ISSUE);
        rsp_ok     = (state_q == S_WAIT) && mem_rsp_valid && !mem_rsp_err;
        trap_valid = done && (cause_q != TRAP_NONE);
        trap_cause = cause_q;
        trap_addr  = taddr_q;
        cur_store  = store_q;
        cur_idx    = idx_q;
    end
endmodule

// File: rtl/lsp_reg_port.sv
// Register-file steering for the current word.
// Maps the word half onto the even or odd register of the pair, gates reads
// and writes for pair 0 (zero source, discarded destination) and routes data
// between the register file and the memory port. Combinational.
module lsp_reg_port #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              issue,
    input  logic              rsp_ok,
    input  logic              word_hi,
    input  logic              is_store,
    input  logic [IDX_W-1:0]  pair_idx,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              rf_re,
    output logic [IDX_W-1:0]  rf_raddr,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [IDX_W-1:0] reg_idx;
    logic             pair_zero;

    // Register of the pair that holds the current word.
    always_comb begin
        reg_idx   = pair_idx | {{(IDX_W-1){1'b0}}, word_hi};
        pair_zero = (pair_idx == '0);
    end

    // Store source read; pair 0 supplies zero and is never read.
    always_comb begin
        rf_re     = issue && is_store && !pair_zero;
        rf_raddr  = pair_zero ? '0 : reg_idx;
        mem_wdata = rf_re ? rf_rdata : '0;
    end

    // Load writeback; pair 0 discards the data.
    always_comb begin
        rf_we    = rsp_ok && !is_store && !pair_zero;
        rf_waddr = reg_idx;
        rf_wdata = rsp_rdata;
    end
endmodule

// File: rtl/lsp_pair_unit.sv
// Paired-register doubleword load/store sequencer (top).
// Accepts one decoded operation while idle, traps bad operands up front,
// otherwise performs two word transactions in restart-safe order.
// Assumes rf_rdata is a combinational read of rf_raddr and that the memory
// returns one response per accepted request, at least one cycle later.
module lsp_pair_unit
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [ADDR_W-1:0] op_base,
    input  logic [IDX_W-1:0]  op_base_idx,
    input  logic [OFF_W-1:0]  op_offset,
    input  logic [IDX_W-1:0]  op_data_idx,
    output logic              busy,
    output logic              done,
    output logic              trap_valid,
    output logic [1:0]        trap_cause,
    output logic [ADDR_W-1:0] trap_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              rf_re,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic [ADDR_W-1:0] ea;
    trap_e             chk_cause;
    trap_e             cause_o;
    logic              accept;
    logic              issue;
    logic              rsp_ok;
    logic              word_hi;
    logic              cur_store;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] word_addr;

    // Offers are only taken while idle.
    always_comb begin
        accept = op_valid && !busy;
    end

    lsp_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
    ) i_addr (
        .base     (op_base),
        .offset   (op_offset),
        .data_idx (op_data_idx),
        .ea       (ea),
        .cause    (chk_cause)
    );

    lsp_seq_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (accept),
        .op_store      (op_store),
        .op_base_idx   (op_base_idx),
        .op_data_idx   (op_data_idx),
        .ea_in         (ea),
        .chk_cause     (chk_cause),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .busy          (busy),
        .done          (done),
        .trap_valid    (trap_valid),
        .trap_cause    (cause_o),
        .trap_addr     (trap_addr),
        .issue         (issue),
        .rsp_ok        (rsp_ok),
        .word_hi       (word_hi),
        .cur_store     (cur_store),
        .cur_idx       (cur_idx),
        .word_addr     (word_addr)
    );

    lsp_reg_port #(
        .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) i_regs (
        .issue     (issue),
        .rsp_ok    (rsp_ok),
        .word_hi   (word_hi),
        .is_store  (cur_store),
        .pair_idx  (cur_idx),
        .rf_rdata  (rf_rdata),
        .rsp_rdata (mem_rsp_rdata),
        .rf_re     (rf_re),
        .rf_raddr  (rf_raddr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .mem_wdata (mem_req_wdata)
    );

    // Memory request port and trap cause encoding.
    always_comb begin
        mem_req_valid = issue;
        mem_req_we    = cur_store;
        mem_req_addr  = word_addr;
        trap_cause    = cause_o;
    end
endmodule

// File: rtl/lsp_pair_unit_chk.sv
// Property checker for lsp_pair_unit, attached with bind.
// Tracks the base index and the number of register writes of the operation
// in flight to check restart-safe ordering at the ports.
module lsp_pair_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [IDX_W-1:0]  op_base_idx,
    input logic              busy,
    input logic              done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              rf_re,
    input logic [IDX_W-1:0]  rf_raddr,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_waddr
);
    logic [IDX_W-1:0] base_q;
    logic             first_wr_q;

    // Record the base index and arm the first-write flag at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            first_wr_q <= 1'b0;
        end else if (op_valid && !busy) begin
            base_q     <= op_base_idx;
            first_wr_q <= 1'b1;
        end else if (rf_we) begin
            first_wr_q <= 1'b0;
        end
    end

    // R6: the first write of an operation never hits the base register
    a_r6_base_last: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && first_wr_q |-> rf_waddr != base_q);

    // R3: transactions are word aligned
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    // R9: registers 0 and 1 are never written
    a_r9_no_low_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr > IDX_W'(1));

    // R10: registers 0 and 1 are never read for stores
    a_r10_no_low_pair_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> rf_raddr > IDX_W'(1));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: requests only while busy, and held stable until accepted
    a_r12_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind lsp_pair_unit lsp_pair_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_base_idx   (op_base_idx),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rf_re         (rf_re),
    .rf_raddr      (rf_raddr),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr)
);

// File: tb/test_lsp_pair_unit.sv
module test_lsp_pair_unit;
    typedef struct packed {
        logic        st;
        logic [31:0] base;
        logic [4:0]  bidx;
        logic [11:0] off;
        logic [4:0]  rg;
        logic [1:0]  errw;   // 0 none, 1 lower word errors, 2 upper word errors
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_1000, 5'd5,  12'h010, 5'd8,  2'd0},  // R1 R4 R5 8-aligned
        '{1'b0, 32'h0000_2000, 5'd3,  12'hFF8, 5'd10, 2'd0},  // R1 negative disp
        '{1'b0, 32'h0000_3004, 5'd3,  12'h000, 5'd12, 2'd0},  // R4 4-aligned only
        '{1'b0, 32'h0000_4000, 5'd14, 12'h020, 5'd14, 2'd0},  // R6 base = even reg
        '{1'b0, 32'h0000_4800, 5'd17, 12'h008, 5'd16, 2'd0},  // R6 base = odd reg
        '{1'b0, 32'h0000_5000, 5'd2,  12'h000, 5'd0,  2'd0},  // R9 load to pair 0
        '{1'b1, 32'h0000_6000, 5'd2,  12'h008, 5'd6,  2'd0},  // R11 store
        '{1'b1, 32'h0000_6100, 5'd0,  12'h000, 5'd0,  2'd0},  // R10 store pair 0
        '{1'b0, 32'h0000_7000, 5'd2,  12'h000, 5'd7,  2'd0},  // R2 odd index
        '{1'b0, 32'h0000_7002, 5'd2,  12'h000, 5'd4,  2'd0},  // R3 misaligned
        '{1'b1, 32'h0000_7000, 5'd2,  12'h001, 5'd9,  2'd0},  // R2 priority over R3
        '{1'b0, 32'h0000_8000, 5'd3,  12'h000, 5'd18, 2'd1},  // R7 first word err
        '{1'b0, 32'h0000_8800, 5'd20, 12'h000, 5'd20, 2'd1},  // R8 second err, base kept
        '{1'b1, 32'h0000_9000, 5'd3,  12'h000, 5'd22, 2'd2},  // R8 store second err
        '{1'b0, 32'h0000_9800, 5'd24, 12'h000, 5'd24, 2'd2}   // R7 reversed first err
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_store = 1'b0;
    logic [31:0] op_base = '0;
    logic [4:0]  op_base_idx = '0;
    logic [11:0] op_offset = '0;
    logic [4:0]  op_data_idx = '0;
    logic        busy, done, trap_valid;
    logic [1:0]  trap_cause;
    logic [31:0] trap_addr;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [31:0] mem_rsp_rdata;
    logic        rf_re, rf_we;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;

    logic        mem_ready_en = 1'b1;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        rsp_q;
    logic [31:0] rsp_addr_q;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // event log filled by the monitor
    int          n_req, n_wr, n_done, n_lowread;
    logic [31:0] req_addr [4];
    logic        req_we   [4];
    logic [31:0] req_wd   [4];
    logic [4:0]  wr_idx   [4];
    logic [31:0] wr_data  [4];
    logic        t_valid;
    logic [1:0]  t_cause;
    logic [31:0] t_addr;

    always #2.5 clk = ~clk;

    lsp_pair_unit i_lsp_pair_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
        .op_base(op_base), .op_base_idx(op_base_idx), .op_offset(op_offset),
        .op_data_idx(op_data_idx), .busy(busy), .done(done),
        .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_addr(trap_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] rfval(input logic [4:0] i);
        return 32'hA000_0000 | (32'(i) << 8) | 32'(i);
    endfunction

    // memory and register file models
    assign mem_req_ready = mem_ready_en;
    assign rf_rdata      = rfval(rf_raddr);
    assign mem_rsp_valid = rsp_q;
    assign mem_rsp_err   = rsp_q && (rsp_addr_q == err_addr);
    assign mem_rsp_rdata = memval(rsp_addr_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= 1'b0;
            rsp_addr_q <= '0;
        end else begin
            rsp_q      <= mem_req_valid && mem_req_ready;
            rsp_addr_q <= mem_req_addr;
        end
    end

    // monitor samples on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && mem_req_ready && n_req < 4) begin
                req_addr[n_req] = mem_req_addr;
                req_we[n_req]   = mem_req_we;
                req_wd[n_req]   = mem_req_wdata;
                n_req++;
            end
            if (rf_we && n_wr < 4) begin
                wr_idx[n_wr]  = rf_waddr;
                wr_data[n_wr] = rf_wdata;
                n_wr++;
            end
            if (rf_re && rf_raddr < 5'd2) n_lowread++;
            if (done) begin
                n_done++;
                t_valid = trap_valid;
                t_cause = trap_cause;
                t_addr  = trap_addr;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_req = 0; n_wr = 0; n_done = 0; n_lowread = 0;
        t_valid = 1'b0; t_cause = 2'd0; t_addr = '0;
    endtask

    task automatic drive(input vec_t v, input logic val);
        op_valid    = val;
        op_store    = v.st;
        op_base     = v.base;
        op_base_idx = v.bidx;
        op_offset   = v.off;
        op_data_idx = v.rg;
    endtask

    task automatic start_op(input vec_t v);
        logic [31:0] ea;
        ea = v.base + {{20{v.off[11]}}, v.off};
        err_addr = (v.errw == 2'd1) ? ea : (v.errw == 2'd2) ? ea + 32'd4 : 32'hFFFF_FFFF;
        @(negedge clk);
        drive(v, 1'b1);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // wait for completion, then compare the log against the requirements
    task automatic finish_op(input vec_t v, input int idx);
        logic [31:0] ea, waddr;
        logic        first_hi, hi, err_any, fault;
        int          err_pos, exp_req, exp_wr, k;
        logic [1:0]  exp_cause;
        logic [31:0] exp_taddr;
        while (n_done == 0) @(posedge clk);
        #1;
        ea = v.base + {{20{v.off[11]}}, v.off};
        first_hi = !v.st && (v.rg != 0) && (v.bidx == v.rg);
        err_any = (v.errw != 0);
        err_pos = !err_any ? 2 : (((v.errw == 2'd2) == first_hi) ? 0 : 1);
        exp_taddr = '0;
        if (v.rg[0]) begin
            exp_cause = 2'd1; exp_req = 0; exp_taddr = ea;
        end else if (ea[1:0] != 0) begin
            exp_cause = 2'd2; exp_req = 0; exp_taddr = ea;
        end else if (err_any) begin
            exp_cause = 2'd3; exp_req = err_pos + 1;
            exp_taddr = ((err_pos == 0) == first_hi) ? ea + 32'd4 : ea;
        end else begin
            exp_cause = 2'd0; exp_req = 2;
        end
        chk(n_done == 1, $sformatf("R12 v%0d done count", idx), 32'(n_done), 32'd1);
        chk(t_cause == exp_cause, $sformatf("R2 R3 R7 v%0d trap cause", idx), 32'(t_cause), 32'(exp_cause));
        chk(t_valid == (exp_cause != 0), $sformatf("R4 v%0d trap valid", idx), 32'(t_valid), 32'(exp_cause != 0));
        if (exp_cause != 0)
            chk(t_addr == exp_taddr, $sformatf("R3 R7 R8 v%0d trap addr", idx), t_addr, exp_taddr);
        chk(n_req == exp_req, $sformatf("R2 R7 v%0d request count", idx), 32'(n_req), 32'(exp_req));
        exp_wr = 0;
        for (int p = 0; p < exp_req && p < n_req; p++) begin
            hi = first_hi ^ (p == 1);
            waddr = ea + (hi ? 32'd4 : 32'd0);
            chk(req_addr[p] == waddr, $sformatf("R1 R6 v%0d req%0d addr", idx, p), req_addr[p], waddr);
            chk(req_we[p] == v.st, $sformatf("R11 v%0d req%0d we", idx, p), 32'(req_we[p]), 32'(v.st));
            if (v.st) begin
                chk(req_wd[p] == ((v.rg == 0) ? 32'd0 : rfval(v.rg | 5'(hi))),
                    $sformatf("R10 R11 v%0d req%0d wdata", idx, p), req_wd[p],
                    (v.rg == 0) ? 32'd0 : rfval(v.rg | 5'(hi)));
            end
            fault = err_any && (p == err_pos);
            if (!v.st && v.rg != 0 && !fault) begin
                k = exp_wr;
                exp_wr++;
                if (k < n_wr) begin
                    chk(wr_idx[k] == (v.rg | 5'(hi)), $sformatf("R5 R6 v%0d wr%0d reg", idx, k),
                        32'(wr_idx[k]), 32'(v.rg | 5'(hi)));
                    chk(wr_data[k] == memval(waddr), $sformatf("R5 v%0d wr%0d data", idx, k),
                        wr_data[k], memval(waddr));
                end
            end
        end
        chk(n_wr == exp_wr, $sformatf("R7 R8 R9 v%0d write count", idx), 32'(n_wr), 32'(exp_wr));
        chk(n_lowread == 0, $sformatf("R10 v%0d no read of pair 0", idx), 32'(n_lowread), 32'd0);
    endtask

    initial begin
        vec_t va, vb;
        clear_log();
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(!busy && !done, "R13 busy/done in reset", {30'd0, busy, done}, 32'd0);
        chk(!mem_req_valid && !rf_we, "R13 req/we in reset", {30'd0, mem_req_valid, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !rf_we, "R13 idle after reset",
            {29'd0, busy, mem_req_valid, rf_we}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            clear_log();
            start_op(VECS[i]);
            finish_op(VECS[i], i);
            repeat (2) @(negedge clk);
        end

        // R12: request stall and op_valid ignored while busy
        va = '{1'b0, 32'h0000_A000, 5'd3, 12'h018, 5'd26, 2'd0};
        vb = '{1'b1, 32'h0000_B000, 5'd3, 12'h000, 5'd28, 2'd0};
        clear_log();
        mem_ready_en = 1'b0;
        start_op(va);
        for (int c = 0; c < 4; c++) begin
            drive(vb, 1'b1);
            chk(busy == 1'b1, "R12 busy during stalled op", 32'(busy), 32'd1);
            @(negedge clk);
        end
        op_valid = 1'b0;
        chk(n_req == 0, "R12 no request accepted during stall", 32'(n_req), 32'd0);
        mem_ready_en = 1'b1;
        finish_op(va, 100);
        @(negedge clk);
        chk(busy == 1'b0, "R12 idle after done", 32'(busy), 32'd0);

        // R12: back-to-back operations with ready toggling
        clear_log();
        start_op(VECS[6]);
        mem_ready_en = 1'b0;
        repeat (2) @(negedge clk);
        mem_ready_en = 1'b1;
        finish_op(VECS[6], 101);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule